// File: doc/BRIEF.md
# Serial Adapter Register and Interrupt Controller

This block is the processor side of an asynchronous serial adapter. A small bus (chip select, 2-bit offset, read and write strobes, 8-bit data) reaches four registers. Offset 0 is the data port: a write fills the transmit holding register and a read takes the last received character. Offset 1 reads back status. A write to offset 1 is a partial soft reset and its data is not used. Offsets 2 and 3 hold the command and control settings, and both can be read back.

The shifting engines are outside the block. The transmitter sees a held byte and a "holding full" level, and it answers with a one-cycle take strobe. The receiver delivers a one-cycle valid strobe together with the character and its parity-error and framing-error flags. The block keeps the status flags and the modem-control outputs. It also merges the enabled events into one interrupt flag, which shows up as status bit 7 and as an active-low pin.

Top module: `acia_regif`

## Requirements
- R1: After hardware reset, command and control read 0x00. Status reads with bit 7 (IRQ) = 0, bit 4 (transmit empty) = 1, bits 3..0 = 0, bit 5 = DCD level and bit 6 = DSR level. `irq_n`, `dtr_n` and `rts_n` are high.
- R2: Writes to offset 2 (command) and offset 3 (control) read back unchanged. Control is driven on `ctrl_cfg`, and command bits 7..5 are driven on `par_mode`.
- R3: A write to offset 1 clears command bits 4..0 and the overrun flag (status bit 2). It leaves command bits 7..5, the control register and the receive-full flag unchanged, and the written data has no effect.
- R4: A write to offset 0 stores the byte on `tx_data`, clears status bit 4 and raises `tx_full`. A `tx_take` pulse sets status bit 4 again.
- R5: A `rx_valid` pulse while the receiver is enabled and status bit 3 (receive full) is 0 stores the character. It sets bit 3, loads bit 0 (parity error) and bit 1 (framing error) from the strobes, and clears bit 2. A read of offset 0 returns the character and clears bit 3.
- R6: A `rx_valid` pulse while bit 3 is set raises bit 2 (overrun) and keeps the stored character and the other error bits. Error bits stay set across the data read and clear only on the next accepted clean character.
- R7: With command bit 0 = 0, `dtr_n` is high, `rx_en` is low and `rx_valid` is ignored. With bit 0 = 1, `dtr_n` is low.
- R8: With command bit 0 = 1 and bit 1 = 0, an accepted character sets IRQ (status bit 7, `irq_n` low) one cycle later. With bit 1 = 1 it does not.
- R9: With command bit 0 = 1 and bits 3:2 = 01, a `tx_take` that empties the holding register sets IRQ. With any other value of bits 3:2 it does not.
- R10: A read of offset 1 returns the current IRQ and clears it in the next cycle. Overrun, parity and framing errors never set IRQ.
- R11: `rts_n` is high only when command bits 3:2 = 00. `tx_break` is high when bits 3:2 = 11. `echo_en` follows command bit 4.
- R12: Status bits 5 and 6 follow the `dcd_in` and `dsr_in` levels at the time of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cs | input | 1 | Chip select |
| addr | input | 2 | Register offset |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected offset |
| irq_n | output | 1 | Active-low interrupt request |
| tx_data | output | 8 | Transmit holding byte |
| tx_full | output | 1 | Holding register has a byte to send |
| tx_take | input | 1 | Transmitter took the held byte |
| rx_valid | input | 1 | Receiver delivers a character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error on this character |
| rx_ferr | input | 1 | Framing error on this character |
| dcd_in | input | 1 | Carrier detect level |
| dsr_in | input | 1 | Data set ready level |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| tx_break | output | 1 | Transmitter sends break |
| echo_en | output | 1 | Receiver echo mode |
| rx_en | output | 1 | Receiver enabled |
| par_mode | output | 3 | Parity setting (command bits 7..5) |
| ctrl_cfg | output | 8 | Control register contents |

## Verification
The bench targets the ordering of the read-to-clear rules. An error flag must survive the data read and clear only on a later clean character. A design that cleared errors on the read, or on any arrival, would lose the parity, framing or overrun report. A character that arrives while the register is full must raise overrun and must not overwrite the stored byte; a design that got this wrong would return the second byte. The soft reset must spare the parity bits, the control register and the receive-full flag, or a driver would see its framing setup wiped. IRQ must stay quiet on error-only events and on masked sources, and it must drop only after a status read.

// File: rtl/acia_pkg.sv
package acia_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_STAT = 2'd1,
    OFS_CMD  = 2'd2,
    OFS_CTRL = 2'd3
  } ofs_e;

  typedef struct packed {
    logic irq;
    logic dsr;
    logic dcd;
    logic tdre;
    logic rdrf;
    logic ovr;
    logic fe;
    logic pe;
  } stat_t;

  // receive-full interrupt allowed: terminal ready and bit 1 low
  function automatic logic rx_irq_allowed(input logic [REG_W-1:0] cmd);
    return cmd[0] & ~cmd[1];
  endfunction

  // transmit-empty interrupt allowed: terminal ready and bits 3:2 = 01
  function automatic logic tx_irq_allowed(input logic [REG_W-1:0] cmd);
    return cmd[0] & (cmd[3:2] == 2'b01);
  endfunction

  // partial reset keeps the parity field only
  function automatic logic [REG_W-1:0] soft_cmd(input logic [REG_W-1:0] cmd);
    return {cmd[7:5], 5'b00000};
  endfunction
endpackage

// File: rtl/acia_cfg.sv
module acia_cfg
  import acia_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          ctrl_we,
  input  logic          soft_rst,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd,
  output logic [DW-1:0] ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= '0;
      ctrl <= '0;
    end else begin
      if (soft_rst)    cmd <= soft_cmd(cmd);
      else if (cmd_we) cmd <= wdata;
      if (ctrl_we)     ctrl <= wdata;
    end
  end

  // R3
  soft_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cmd[4:0] == 5'd0) && (cmd[7:5] == $past(cmd[7:5])) && $stable(ctrl));
endmodule

// File: rtl/acia_rx.sv
module acia_rx
  import acia_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          data_rd,
  input  logic          soft_rst,
  output logic [DW-1:0] rx_hold,
  output logic          rdrf,
  output logic          ovr,
  output logic          fe,
  output logic          pe,
  output logic          rx_accept,
  output logic          rx_orun
);
  assign rx_accept = rx_valid & rx_en & ~rdrf;
  assign rx_orun   = rx_valid & rx_en & rdrf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold <= '0;
      rdrf    <= 1'b0;
      ovr     <= 1'b0;
      fe      <= 1'b0;
      pe      <= 1'b0;
    end else begin
      if (rx_accept) begin
        rx_hold <= rx_data;
        pe      <= rx_perr;
        fe      <= rx_ferr;
      end
      if (rx_accept)    rdrf <= 1'b1;
      else if (data_rd) rdrf <= 1'b0;
      if (soft_rst)       ovr <= 1'b0;
      else if (rx_accept) ovr <= 1'b0;
      else if (rx_orun)   ovr <= 1'b1;
    end
  end

  // R6
  orun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_orun && !soft_rst) |=> ovr && $stable(rx_hold) && $stable(pe) && $stable(fe));
  // R7
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_en) |=> $stable(rx_hold) && (rdrf == ($past(rdrf) && !$past(data_rd))));
  // R5
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |=> rdrf && (rx_hold == $past(rx_data)));
endmodule

// File: rtl/acia_tx.sv
module acia_tx
  import acia_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  input  logic          tx_take,
  output logic [DW-1:0] tx_hold,
  output logic          tdre,
  output logic          tx_empty_evt
);
  assign tx_empty_evt = tx_take & ~tdre & ~data_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold <= '0;
      tdre    <= 1'b1;
    end else if (data_we) begin
      tx_hold <= wdata;
      tdre    <= 1'b0;
    end else if (tx_take) begin
      tdre    <= 1'b1;
    end
  end

  // R4
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> !tdre && (tx_hold == $past(wdata)));
endmodule

// File: rtl/acia_irq.sv
module acia_irq
  import acia_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cmd,
  input  logic          rx_evt,
  input  logic          tx_evt,
  input  logic          stat_rd,
  output logic          irq,
  output logic          irq_set
);
  assign irq_set = (rx_evt & rx_irq_allowed(cmd)) | (tx_evt & tx_irq_allowed(cmd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (stat_rd) irq <= 1'b0;
  end

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_set) |=> !irq);
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !irq_set) |=> !irq);
endmodule

// File: rtl/acia_regif.sv
module acia_regif
  import acia_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_n,
  output logic [DW-1:0] tx_data,
  output logic          tx_full,
  input  logic          tx_take,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          dcd_in,
  input  logic          dsr_in,
  output logic          dtr_n,
  output logic          rts_n,
  output logic          tx_break,
  output logic          echo_en,
  output logic          rx_en,
  output logic [2:0]    par_mode,
  output logic [DW-1:0] ctrl_cfg
);
  ofs_e ofs;
  assign ofs = ofs_e'(addr);

  logic data_we, soft_rst, cmd_we, ctrl_we, data_rd, stat_rd;
  assign data_we  = cs & wr & (ofs == OFS_DATA);
  assign soft_rst = cs & wr & (ofs == OFS_STAT);
  assign cmd_we   = cs & wr & (ofs == OFS_CMD);
  assign ctrl_we  = cs & wr & (ofs == OFS_CTRL);
  assign data_rd  = cs & rd & (ofs == OFS_DATA);
  assign stat_rd  = cs & rd & (ofs == OFS_STAT);

  logic [DW-1:0] cmd, ctrl, rx_hold;
  logic rdrf, ovr, fe, pe, rx_accept, rx_orun;
  logic tdre, tx_empty_evt, irq, irq_set;

  acia_cfg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .ctrl_we(ctrl_we),
    .soft_rst(soft_rst), .wdata(wdata), .cmd(cmd), .ctrl(ctrl)
  );

  acia_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .data_rd(data_rd), .soft_rst(soft_rst), .rx_hold(rx_hold),
    .rdrf(rdrf), .ovr(ovr), .fe(fe), .pe(pe),
    .rx_accept(rx_accept), .rx_orun(rx_orun)
  );

  acia_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .wdata(wdata),
    .tx_take(tx_take), .tx_hold(tx_data), .tdre(tdre),
    .tx_empty_evt(tx_empty_evt)
  );

  acia_irq #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .rx_evt(rx_accept),
    .tx_evt(tx_empty_evt), .stat_rd(stat_rd), .irq(irq), .irq_set(irq_set)
  );

  stat_t stat;
  always_comb begin
    stat      = '0;
    stat.irq  = irq;
    stat.dsr  = dsr_in;
    stat.dcd  = dcd_in;
    stat.tdre = tdre;
    stat.rdrf = rdrf;
    stat.ovr  = ovr;
    stat.fe   = fe;
    stat.pe   = pe;
  end

  always_comb begin
    unique case (ofs)
      OFS_DATA: rdata = rx_hold;
      OFS_STAT: rdata = stat;
      OFS_CMD:  rdata = cmd;
      default:  rdata = ctrl;
    endcase
  end

  assign irq_n    = ~irq;
  assign tx_full  = ~tdre;
  assign rx_en    = cmd[0];
  assign dtr_n    = ~cmd[0];
  assign rts_n    = (cmd[3:2] == 2'b00);
  assign tx_break = (cmd[3:2] == 2'b11);
  assign echo_en  = cmd[4];
  assign par_mode = cmd[7:5];
  assign ctrl_cfg = ctrl;

  // R10
  err_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_orun && !irq && !tx_empty_evt) |=> !irq);
  // R9
  tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !tdre && !data_we && cmd[0] && cmd[3:2] == 2'b01) |=> !irq_n);
endmodule

// File: tb/sim_acia_regif.sv
`timescale 1ns/1ps
module sim_acia_regif;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs, wr, rd, tx_take, rx_valid, rx_perr, rx_ferr, dcd_in, dsr_in;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, tx_data, rx_data, ctrl_cfg;
  logic irq_n, tx_full, dtr_n, rts_n, tx_break, echo_en, rx_en;
  logic [2:0] par_mode;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  acia_regif u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .tx_data(tx_data),
    .tx_full(tx_full), .tx_take(tx_take), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .dcd_in(dcd_in), .dsr_in(dsr_in), .dtr_n(dtr_n), .rts_n(rts_n),
    .tx_break(tx_break), .echo_en(echo_en), .rx_en(rx_en),
    .par_mode(par_mode), .ctrl_cfg(ctrl_cfg)
  );

  function automatic logic [7:0] st(input logic irq, dsr, dcd, tdre, rdrf, ovr, fe, pe);
    return {irq, dsr, dcd, tdre, rdrf, ovr, fe, pe};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0; wdata = 8'h00;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic rx_char(input logic [7:0] d, input logic p, input logic f);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f;
    @(negedge clk); rx_valid = 0; rx_perr = 0; rx_ferr = 0;
  endtask

  task automatic take_pulse();
    @(negedge clk); tx_take = 1;
    @(negedge clk); tx_take = 0;
  endtask

  task automatic t_reset();
    dcd_in = 1; dsr_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 dtr_n", {7'd0, dtr_n}, 8'h01);
    chk("R1 rts_n", {7'd0, rts_n}, 8'h01);
    rd_chk("R1 status", 2'd1, st(0, 0, 1, 1, 0, 0, 0, 0));
    rd_chk("R1 command", 2'd2, 8'h00);
    rd_chk("R1 control", 2'd3, 8'h00);
    dcd_in = 0;
  endtask

  task automatic t_regs();
    bus_wr(2'd3, 8'hA5);
    rd_chk("R2 control", 2'd3, 8'hA5);
    chk("R2 ctrl_cfg", ctrl_cfg, 8'hA5);
    bus_wr(2'd2, 8'h6B);
    rd_chk("R2 command", 2'd2, 8'h6B);
    chk("R2 par_mode", {5'd0, par_mode}, 8'h03);
    chk("R11 rts_n 10", {7'd0, rts_n}, 8'h00);
    chk("R11 brk 10", {7'd0, tx_break}, 8'h00);
    chk("R7 dtr_n on", {7'd0, dtr_n}, 8'h00);
    bus_wr(2'd2, 8'h0D);
    chk("R11 brk 11", {7'd0, tx_break}, 8'h01);
    chk("R11 rts_n 11", {7'd0, rts_n}, 8'h00);
    bus_wr(2'd2, 8'h11);
    chk("R11 echo", {7'd0, echo_en}, 8'h01);
    chk("R11 rts_n 00", {7'd0, rts_n}, 8'h01);
    bus_wr(2'd2, 8'h00);
  endtask

  task automatic t_lines();
    dsr_in = 1; dcd_in = 0;
    rd_chk("R12 dsr", 2'd1, st(0, 1, 0, 1, 0, 0, 0, 0));
    dsr_in = 0; dcd_in = 1;
    rd_chk("R12 dcd", 2'd1, st(0, 0, 1, 1, 0, 0, 0, 0));
    dcd_in = 0;
  endtask

  task automatic t_rx();
    bus_wr(2'd2, 8'h09);
    rx_char(8'h5A, 1, 0);
    chk("R8 irq_n rx", {7'd0, irq_n}, 8'h00);
    rd_chk("R5 status pe", 2'd1, st(1, 0, 0, 1, 1, 0, 0, 1));
    rd_chk("R10 irq cleared", 2'd1, st(0, 0, 0, 1, 1, 0, 0, 1));
    rd_chk("R5 data", 2'd0, 8'h5A);
    rd_chk("R6 pe kept after read", 2'd1, st(0, 0, 0, 1, 0, 0, 0, 1));
    rx_char(8'h33, 0, 1);
    rd_chk("R5 status fe", 2'd1, st(1, 0, 0, 1, 1, 0, 1, 0));
    rd_chk("R5 data fe", 2'd0, 8'h33);
    rx_char(8'h34, 0, 0);
    rd_chk("R6 clean clears fe", 2'd1, st(1, 0, 0, 1, 1, 0, 0, 0));
    rd_chk("R5 data clean", 2'd0, 8'h34);
    rd_chk("R5 rdrf cleared", 2'd1, st(0, 0, 0, 1, 0, 0, 0, 0));
  endtask

  task automatic t_overrun();
    rx_char(8'h11, 0, 0);
    rd_chk("R8 irq first", 2'd1, st(1, 0, 0, 1, 1, 0, 0, 0));
    rx_char(8'h22, 0, 1);
    chk("R10 overrun no irq", {7'd0, irq_n}, 8'h01);
    rd_chk("R6 overrun", 2'd1, st(0, 0, 0, 1, 1, 1, 0, 0));
    rd_chk("R6 data kept", 2'd0, 8'h11);
    rd_chk("R6 ovr after read", 2'd1, st(0, 0, 0, 1, 0, 1, 0, 0));
    rx_char(8'h23, 0, 0);
    rd_chk("R6 ovr cleared", 2'd1, st(1, 0, 0, 1, 1, 0, 0, 0));
    rd_chk("R5 data after ovr", 2'd0, 8'h23);
    rd_chk("R5 idle", 2'd1, st(0, 0, 0, 1, 0, 0, 0, 0));
  endtask

  task automatic t_soft();
    bus_wr(2'd2, 8'hE7);
    bus_wr(2'd3, 8'h3C);
    rx_char(8'h41, 0, 0);
    rx_char(8'h42, 0, 0);
    rd_chk("R8 rx irq masked", 2'd1, st(0, 0, 0, 1, 1, 1, 0, 0));
    bus_wr(2'd1, 8'hFF);
    rd_chk("R3 command", 2'd2, 8'hE0);
    rd_chk("R3 control", 2'd3, 8'h3C);
    rd_chk("R3 status", 2'd1, st(0, 0, 0, 1, 1, 0, 0, 0));
    rd_chk("R3 data", 2'd0, 8'h41);
    chk("R3 rx_en off", {7'd0, rx_en}, 8'h00);
  endtask

  task automatic t_dtr_off();
    bus_wr(2'd2, 8'h00);
    chk("R7 dtr_n off", {7'd0, dtr_n}, 8'h01);
    rx_char(8'h55, 1, 1);
    rd_chk("R7 status", 2'd1, st(0, 0, 0, 1, 0, 0, 0, 0));
    rd_chk("R7 data", 2'd0, 8'h41);
  endtask

  task automatic t_rxirq_dis();
    bus_wr(2'd2, 8'h0B);
    rx_char(8'h66, 0, 0);
    chk("R8 masked irq_n", {7'd0, irq_n}, 8'h01);
    rd_chk("R8 masked status", 2'd1, st(0, 0, 0, 1, 1, 0, 0, 0));
    rd_chk("R5 data 66", 2'd0, 8'h66);
  endtask

  task automatic t_tx();
    bus_wr(2'd2, 8'h05);
    bus_wr(2'd0, 8'h77);
    chk("R4 tx_data", tx_data, 8'h77);
    chk("R4 tx_full", {7'd0, tx_full}, 8'h01);
    rd_chk("R4 tdre low", 2'd1, st(0, 0, 0, 0, 0, 0, 0, 0));
    take_pulse();
    chk("R9 irq_n tx", {7'd0, irq_n}, 8'h00);
    rd_chk("R9 status", 2'd1, st(1, 0, 0, 1, 0, 0, 0, 0));
    rd_chk("R10 tx irq cleared", 2'd1, st(0, 0, 0, 1, 0, 0, 0, 0));
    bus_wr(2'd2, 8'h09);
    bus_wr(2'd0, 8'h78);
    take_pulse();
    chk("R9 masked irq_n", {7'd0, irq_n}, 8'h01);
    rd_chk("R4 tdre set", 2'd1, st(0, 0, 0, 1, 0, 0, 0, 0));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cs = 0; wr = 0; rd = 0; addr = 0; wdata = 0;
    tx_take = 0; rx_valid = 0; rx_data = 0; rx_perr = 0; rx_ferr = 0;
    dcd_in = 0; dsr_in = 0; rst_n = 0;
    t_reset();
    t_regs();
    t_lines();
    t_rx();
    t_overrun();
    t_soft();
    t_dtr_off();
    t_rxirq_dis();
    t_tx();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule